// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block takes a stereo serial audio stream made of a bit clock, a channel clock and a data line, and turns it into parallel left and right samples. All three lines are treated as asynchronous inputs: they are synchronised into the system clock domain, and bit-clock rising edges are found by comparing the synchronised level with its previous value. On each bit-clock rising edge the block samples the data line and the channel clock.

Two framings are supported. In the right-justified framing the word is sent MSB first and its LSB is the last bit before the channel clock changes; the word length is 16 or 20 bits. In the 32-clock I2S framing only 16-bit words are allowed. Each word is placed in a 20-bit two's-complement output, and 16-bit words are padded with zeros at the bottom. A one-cycle strobe marks each completed left/right pair.

Two further functions sit beside the capture path. After reset, a hold-off suppresses results until a set number of channel-clock periods has gone by. A run detector raises a flag when the data line has stayed at one level for a long time. Framing, word length, channel polarity and the enable for the run detector are static configuration inputs.

Top module: `serial_audio_rx`

## Requirements
- R1: In right-justified framing (`cfgI2s`=0), the word that ends at a channel-clock change is made of the last N bits sampled before the bit-clock edge that sees the change, MSB first. Slot bits sent earlier than those N bits have no effect on the result.
- R2: `cfgWide`=1 in right-justified framing selects N=20, and the 20 bits appear unchanged on the output. `cfgWide`=0 selects N=16.
- R3: A 16-bit word is output as its 16 bits in output bits [19:4], with bits [3:0] zero.
- R4: In I2S framing (`cfgI2s`=1) the bit sampled at the first bit-clock edge after a channel-clock change is ignored. The next 16 sampled bits form the word, MSB first. The remaining bits of the slot are ignored, and `cfgWide` has no effect.
- R5: With `cfgSwap`=0, a slot sent with the channel clock high is left and a slot sent with it low is right. `cfgSwap`=1 swaps this mapping.
- R6: A captured word counts toward a pair only if, before the bit-clock edge that captures it, at least HOLD_FRAMES (default 64) rising channel-clock transitions have been seen since reset.
- R7: `pairValid` is a one-cycle pulse, raised once for each left word followed by a right word that both count. At the pulse, `leftOut` and `rightOut` hold that pair.
- R8: With `cfgZeroDetEn`=1, `zeroFlag` is high once ZERO_RUN (default 65536) consecutive bit-clock edges have each sampled the same data value as the edge before. With `cfgZeroDetEn`=0, `zeroFlag` is low.
- R9: A bit-clock edge that samples a data value different from the previous edge clears the run count, and `zeroFlag` drops right away.
- R10: After reset, `leftOut` and `rightOut` are zero and `pairValid` and `zeroFlag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClkIn | input | 1 | Serial bit clock (asynchronous) |
| chanClkIn | input | 1 | Channel/word clock (asynchronous) |
| dataIn | input | 1 | Serial data |
| cfgI2s | input | 1 | 1: 32-clock I2S framing, 0: right-justified |
| cfgWide | input | 1 | 1: 20-bit words in right-justified framing |
| cfgSwap | input | 1 | Swap the channel-clock to channel mapping |
| cfgZeroDetEn | input | 1 | Enable the constant-data flag |
| leftOut | output | 20 | Left sample, two's complement |
| rightOut | output | 20 | Right sample, two's complement |
| pairValid | output | 1 | One-cycle strobe per completed pair |
| zeroFlag | output | 1 | Constant-data run detected |

## Verification
The hardest case to reach from the ports is the exact frame at which the hold-off opens. That frame differs with channel polarity and framing, because the counted rising channel-clock transitions fall either at frame starts or in the middle of frames. The bench resets before each configuration, shrinks HOLD_FRAMES to 2, and predicts the first reported frame from the polarity. Any early or missing pair then shows up as a scoreboard mismatch. The run detector is reached with a shortened ZERO_RUN and bit-by-bit stimulus on an idle channel clock.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  // Strobes from control to datapath, one set per system clock cycle
  typedef struct packed {
    logic shift;     // a bit-clock rising edge was seen
    logic bitVal;    // data value sampled at that edge
    logic useNew;    // capture includes the bit shifted this cycle
    logic wide;      // effective 20-bit word
    logic capLeft;   // latch word into left register
    logic capRight;  // latch word into right register
    logic report;    // completed pair may be announced
  } sarx_strobe_t;
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sarx_ctrl.sv
module sarx_ctrl
  import sarx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_W     = 16,
  parameter int HOLD_FRAMES = 64,
  parameter int ZERO_RUN    = 65536
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         bitClkIn,
  input  logic         chanClkIn,
  input  logic         dataIn,
  input  logic         cfgI2s,
  input  logic         cfgWide,
  input  logic         cfgSwap,
  input  logic         cfgZeroDetEn,
  output sarx_strobe_t strobe,
  output logic         zeroFlag
);
  localparam int SLOT_W   = 6;
  localparam int HOLD_W   = $clog2(HOLD_FRAMES + 1);
  localparam int RUN_W    = $clog2(ZERO_RUN + 1);
  localparam logic [SLOT_W-1:0] SLOT_SAT = '1;
  localparam logic [SLOT_W-1:0] LSB_IDX  = SLOT_W'(SHORT_W - 1);
  localparam logic [HOLD_W-1:0] HOLD_V   = HOLD_W'(HOLD_FRAMES);
  localparam logic [RUN_W-1:0]  RUN_V    = RUN_W'(ZERO_RUN);

  logic [2:0] syncQ;
  logic bclkS, chanS, dataS;
  logic bclkPrev, chanPrev, dataPrev;
  logic bitTick, chanEdge, chanRise;
  logic [SLOT_W-1:0] slotCnt;
  logic [HOLD_W-1:0] riseCnt;
  logic [RUN_W-1:0]  runCnt;
  logic ready, leftSeen, capture, isLeft;

  sarx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk(clk), .rstN(rstN),
    .d({dataIn, chanClkIn, bitClkIn}),
    .q(syncQ)
  );
  assign bclkS = syncQ[0];
  assign chanS = syncQ[1];
  assign dataS = syncQ[2];

  assign bitTick  = bclkS & ~bclkPrev;
  assign chanEdge = bitTick & (chanS ^ chanPrev);
  assign chanRise = chanEdge & chanS;
  assign ready    = (riseCnt == HOLD_V);

  always_comb begin
    if (cfgI2s) begin
      capture = bitTick & ~chanEdge & (slotCnt == LSB_IDX);
      isLeft  = chanS ^ cfgSwap;
    end else begin
      capture = chanEdge;
      isLeft  = chanPrev ^ cfgSwap;
    end
    strobe.shift    = bitTick;
    strobe.bitVal   = dataS;
    strobe.useNew   = cfgI2s;
    strobe.wide     = cfgWide & ~cfgI2s;
    strobe.capLeft  = capture & isLeft;
    strobe.capRight = capture & ~isLeft;
    strobe.report   = capture & ~isLeft & leftSeen & ready;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPrev <= 1'b0;
      chanPrev <= 1'b0;
      dataPrev <= 1'b0;
      slotCnt  <= SLOT_SAT;
      riseCnt  <= '0;
      runCnt   <= '0;
      leftSeen <= 1'b0;
    end else begin
      bclkPrev <= bclkS;
      if (bitTick) begin
        chanPrev <= chanS;
        dataPrev <= dataS;
        if (chanEdge) slotCnt <= '0;
        else if (slotCnt != SLOT_SAT) slotCnt <= slotCnt + 1'b1;
        if (dataS != dataPrev) runCnt <= '0;
        else if (runCnt != RUN_V) runCnt <= runCnt + 1'b1;
      end
      if (chanRise && !ready) riseCnt <= riseCnt + 1'b1;
      if (strobe.capLeft) leftSeen <= ready;
      else if (strobe.capRight) leftSeen <= 1'b0;
    end
  end

  assign zeroFlag = cfgZeroDetEn & (runCnt == RUN_V);

  // R6: hold-off never closes again once open
  p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);
  // R6: a pending left word exists only after the hold-off has opened
  p_seen_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    leftSeen |-> ready);
  // R9: a data change drops the flag on the next cycle
  p_flag_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && (dataS != dataPrev)) |=> !zeroFlag);
  // R8: the flag rises only while enabled and the data is unchanged
  p_flag_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(zeroFlag) |-> (cfgZeroDetEn && (dataS == dataPrev)));
endmodule

// File: rtl/sarx_datapath.sv
module sarx_datapath
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarx_strobe_t        strobe,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                pairValid
);
  localparam int PAD = SAMPLE_W - SHORT_W;

  logic [SAMPLE_W-1:0] shiftReg, nextShift, src, word;

  assign nextShift = {shiftReg[SAMPLE_W-2:0], strobe.bitVal};
  assign src       = strobe.useNew ? nextShift : shiftReg;

  if (PAD > 0) begin : g_pad
    assign word = strobe.wide ? src : {src[SHORT_W-1:0], {PAD{1'b0}}};
    // R3: a short word leaves the low bits zero
    p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.capLeft && !strobe.wide) |=> (leftOut[PAD-1:0] == '0));
  end else begin : g_nopad
    assign word = src;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      leftOut   <= '0;
      rightOut  <= '0;
      pairValid <= 1'b0;
    end else begin
      if (strobe.shift) shiftReg <= nextShift;
      if (strobe.capLeft) leftOut <= word;
      if (strobe.capRight) rightOut <= word;
      pairValid <= strobe.report;
    end
  end

  // R7: the pair strobe lasts one cycle
  p_pair_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> !pairValid);
  // R7: left output holds between captures
  p_left_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capLeft |=> $stable(leftOut));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_W    = 20,
  parameter int SHORT_W     = 16,
  parameter int HOLD_FRAMES = 64,
  parameter int ZERO_RUN    = 65536
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClkIn,
  input  logic                chanClkIn,
  input  logic                dataIn,
  input  logic                cfgI2s,
  input  logic                cfgWide,
  input  logic                cfgSwap,
  input  logic                cfgZeroDetEn,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                pairValid,
  output logic                zeroFlag
);
  sarx_pkg::sarx_strobe_t strobe;

  sarx_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .SHORT_W(SHORT_W),
    .HOLD_FRAMES(HOLD_FRAMES), .ZERO_RUN(ZERO_RUN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .bitClkIn(bitClkIn), .chanClkIn(chanClkIn), .dataIn(dataIn),
    .cfgI2s(cfgI2s), .cfgWide(cfgWide), .cfgSwap(cfgSwap),
    .cfgZeroDetEn(cfgZeroDetEn),
    .strobe(strobe), .zeroFlag(zeroFlag)
  );

  sarx_datapath #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .leftOut(leftOut), .rightOut(rightOut), .pairValid(pairValid)
  );
endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  localparam int HOLD = 2;
  localparam int RUN  = 40;
  localparam int HALF = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, bitClkIn = 1'b0, chanClkIn = 1'b0, dataIn = 1'b0;
  logic cfgI2s = 1'b0, cfgWide = 1'b0, cfgSwap = 1'b0, cfgZeroDetEn = 1'b0;
  logic [19:0] leftOut, rightOut;
  logic pairValid, zeroFlag;

  serial_audio_rx #(.HOLD_FRAMES(HOLD), .ZERO_RUN(RUN)) uut (
    .clk(clk), .rstN(rstN), .bitClkIn(bitClkIn), .chanClkIn(chanClkIn),
    .dataIn(dataIn), .cfgI2s(cfgI2s), .cfgWide(cfgWide), .cfgSwap(cfgSwap),
    .cfgZeroDetEn(cfgZeroDetEn), .leftOut(leftOut), .rightOut(rightOut),
    .pairValid(pairValid), .zeroFlag(zeroFlag)
  );

  int checks = 0, fails = 0;
  string tag = "R7";
  logic [39:0] expQ[$];
  logic [39:0] popped;
  logic pvPrev = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected pair for each strobe
  always @(negedge clk) begin
    if (rstN && pairValid) begin
      check(!pvPrev, "R7", "strobe wider than one cycle", 40'(pvPrev), 40'd0);
      if (expQ.size() == 0)
        check(1'b0, tag, "unexpected pair", {leftOut, rightOut}, 40'd0);
      else begin
        popped = expQ.pop_front();
        check({leftOut, rightOut} == popped, tag, "pair",
              {leftOut, rightOut}, popped);
      end
    end
    pvPrev <= pairValid;
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; bitClkIn = 1'b0; chanClkIn = 1'b0; dataIn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendBit(input logic ch, input logic b);
    chanClkIn = ch; dataIn = b; bitClkIn = 1'b0;
    repeat (HALF) @(negedge clk);
    bitClkIn = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sendSlot(input logic ch, input logic [19:0] w);
    if (cfgI2s) begin
      sendBit(ch, ~w[15]);                        // ignored first bit
      for (int i = 15; i >= 0; i--) sendBit(ch, w[i]);
      for (int i = 0; i < 15; i++) sendBit(ch, i[0]);  // slot filler
    end else begin
      int n;
      n = cfgWide ? 20 : 16;
      for (int i = 0; i < 24 - n; i++) sendBit(ch, ~i[0]);  // leading filler
      for (int i = n - 1; i >= 0; i--) sendBit(ch, w[i]);
    end
  endtask

  function automatic logic [19:0] expWord(input logic [19:0] v);
    return (cfgI2s || !cfgWide) ? {v[15:0], 4'h0} : v;
  endfunction

  task automatic runPhase(input string t, input bit i2s, input bit wide,
                          input bit swap, input int frames, input logic [19:0] seed);
    logic lv;
    int first;
    cfgI2s = i2s; cfgWide = wide; cfgSwap = swap; cfgZeroDetEn = 1'b0;
    doReset();
    tag = t;
    lv = ~swap;
    first = HOLD - 1 + int'(swap);   // R6: first frame whose pair counts
    for (int f = 0; f < frames; f++) begin
      logic [19:0] l, r;
      l = seed + 20'(f) * 20'h13579;
      r = ~l ^ 20'h0A5C3;
      if (f >= first) expQ.push_back({expWord(l), expWord(r)});
      sendSlot(lv, l);
      sendSlot(~lv, r);
    end
    repeat (4) sendBit(lv, 1'b0);
    repeat (30) @(negedge clk);
    check(expQ.size() == 0, t, "pairs not reported", 40'(expQ.size()), 40'd0);
    expQ.delete();
  endtask

  initial begin
    doReset();
    // R10: reset state
    check(leftOut == 20'd0, "R10", "leftOut after reset", 40'(leftOut), 40'd0);
    check(rightOut == 20'd0, "R10", "rightOut after reset", 40'(rightOut), 40'd0);
    check(!pairValid, "R10", "pairValid after reset", 40'(pairValid), 40'd0);
    check(!zeroFlag, "R10", "zeroFlag after reset", 40'(zeroFlag), 40'd0);

    runPhase("R1 R3 R6 right-justified 16-bit", 1'b0, 1'b0, 1'b0, 5, 20'h8F0E1);
    runPhase("R2 right-justified 20-bit", 1'b0, 1'b1, 1'b0, 5, 20'hC3A57);
    runPhase("R5 R6 swapped polarity", 1'b0, 1'b0, 1'b1, 5, 20'h1B2C3);
    runPhase("R4 I2S with width input high", 1'b1, 1'b1, 1'b0, 5, 20'h7E81F);
    runPhase("R4 R5 I2S swapped polarity", 1'b1, 1'b0, 1'b1, 5, 20'h45A96);

    // R8/R9: constant-data run flag
    cfgI2s = 1'b0; cfgWide = 1'b0; cfgSwap = 1'b0; cfgZeroDetEn = 1'b1;
    doReset();
    sendBit(1'b0, 1'b1);
    repeat (RUN) sendBit(1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check(!zeroFlag, "R8", "flag one edge early", 40'(zeroFlag), 40'd0);
    sendBit(1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check(zeroFlag, "R8", "flag after full run", 40'(zeroFlag), 40'd1);
    sendBit(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check(!zeroFlag, "R9", "flag after data change", 40'(zeroFlag), 40'd0);
    cfgZeroDetEn = 1'b0;
    repeat (RUN + 5) sendBit(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check(!zeroFlag, "R8", "flag while disabled", 40'(zeroFlag), 40'd0);
    cfgZeroDetEn = 1'b1;
    @(negedge clk);
    check(zeroFlag, "R8", "flag after enabling on long run", 40'(zeroFlag), 40'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule